// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block converts a parallel word into a serial bit stream. A chain of `DEPTH` stages (default 8) is filled from the parallel inputs. It is then clocked so that the word leaves, one bit per enabled rising edge, from the final stage. The final stage drives a true serial output and an inverted serial output. A serial input feeds the first stage, so that several blocks can be chained or new data can follow the word.

The load control `load_n` is level-sensitive and active low. While it is low, the stages take the parallel word at once, without waiting for a clock edge, and every other input has no effect on the contents. While it is high, each rising clock edge shifts the chain by one stage, unless `hold` is high. A high `hold` freezes the contents while the clock keeps running.

There is no clear input, and the power-up contents are undefined until the first load. The serial pins are plain signals with no valid/ready handshake, so no back-pressure exists: a consumer that cannot accept a bit raises `hold` before the next rising edge. If the parallel word changes while `load_n` is low, at least one rising clock edge must come before `load_n` returns high. That edge makes the retained contents match the word that is present at release.

Top module: `psr_shifter`

## Requirements
- R1: Bit `par_in[DEPTH-1]` belongs to the final stage and `par_in[0]` to the first. After a load and k enabled rising edges (k < DEPTH), `sout` equals `par_in[DEPTH-1-k]` of the loaded word.
- R2: When `load_n` goes low, `sout` shows `par_in[DEPTH-1]` within the same clock period, with no clock edge needed.
- R3: While `load_n` is low, rising clock edges, `hold` and `ser_in` have no effect. After release, the word that shifts out is the parallel word.
- R4: On each enabled edge, `ser_in` is captured into the first stage. The bit fed at an edge reaches `sout` after `DEPTH` enabled edges in total.
- R5: `sout_n` is always the inverse of `sout`.
- R6: While `hold` is high and `load_n` is high, rising clock edges leave the contents and `sout` unchanged.
- R7: After `load_n` rises, the loaded final-stage bit is on `sout` before any edge, and the first enabled edge performs a shift.
- R8: While `load_n` is low, `sout` follows changes of `par_in[DEPTH-1]` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| load_n | input | 1 | Low: load the parallel word asynchronously; high: shift mode |
| hold | input | 1 | High: block shifting |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | DEPTH | Parallel word, bit DEPTH-1 for the final stage |
| sout | output | 1 | Final-stage value |
| sout_n | output | 1 | Inverse of sout |

## Verification
Results from a load (R2, R8) are due with no clock at all, so the bench samples them 1 ns after it changes `load_n` or `par_in`. Results from a shift (R1, R4, R6, R7) appear once, through the single stage register, right after the rising edge. The bench therefore drives inputs on falling edges or 1 ns after a rising edge. It compares a behavioural queue model with both outputs 1 ns after every rising edge.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_DEPTH_DEF = 8;

  // position of the stage that drives the serial output
  function automatic int unsigned psr_last(input int unsigned depth);
    return depth - 1;
  endfunction
endpackage

// File: rtl/psr_gate.sv
// Clock-enable decode: shifting is permitted whenever hold is low.
// The load override is handled asynchronously in each cell, so the
// enable does not depend on load_n.
module psr_gate (
  input  logic hold,
  output logic shift_en
);
  always_comb shift_en = !hold;
endmodule

// File: rtl/psr_cell.sv
// One stage: asynchronous parallel load while load_n is low,
// otherwise takes its predecessor on an enabled rising edge.
module psr_cell (
  input  logic clk,
  input  logic load_n,
  input  logic shift_en,
  input  logic par_bit,
  input  logic d_prev,
  output logic q
);
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)
      q <= par_bit;
    else if (shift_en)
      q <= d_prev;
  end

  // R1: an enabled edge in shift mode moves the predecessor in
  a_r1_stage_advances: assert property (@(posedge clk) disable iff (!load_n)
    (load_n && shift_en) |=> (q == $past(d_prev)));

  // R6: a blocked edge leaves the stage untouched
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!load_n)
    (load_n && !shift_en) |=> $stable(q));

  // R3: edges during load keep the stage on the parallel bit
  a_r3_load_overrides_clock: assert property (@(posedge clk)
    (!load_n) |=> (load_n || q == $past(par_bit)));
endmodule

// File: rtl/psr_tap.sv
// Output tap: while loading, the parallel bit is passed straight
// through so the output tracks it; otherwise the final stage drives.
module psr_tap (
  input  logic load_n,
  input  logic stage_last,
  input  logic par_last,
  output logic sout,
  output logic sout_n
);
  logic bit_out;
  always_comb begin
    bit_out = load_n ? stage_last : par_last;
    sout    = bit_out;
    sout_n  = ~bit_out;
  end
endmodule

// File: rtl/psr_shifter.sv
module psr_shifter #(
  parameter int unsigned DEPTH = psr_pkg::PSR_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             hold,
  input  logic             ser_in,
  input  logic [DEPTH-1:0] par_in,
  output logic             sout,
  output logic             sout_n
);
  localparam int unsigned LAST = psr_pkg::psr_last(DEPTH);

  logic             shift_en;
  logic [DEPTH-1:0] stage;

  psr_gate u_gate (
    .hold     (hold),
    .shift_en (shift_en)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      psr_cell u_cell (
        .clk      (clk),
        .load_n   (load_n),
        .shift_en (shift_en),
        .par_bit  (par_in[i]),
        .d_prev   (ser_in),
        .q        (stage[i])
      );
    end else begin : g_body
      psr_cell u_cell (
        .clk      (clk),
        .load_n   (load_n),
        .shift_en (shift_en),
        .par_bit  (par_in[i]),
        .d_prev   (stage[i-1]),
        .q        (stage[i])
      );
    end
  end

  psr_tap u_tap (
    .load_n     (load_n),
    .stage_last (stage[LAST]),
    .par_last   (par_in[LAST]),
    .sout       (sout),
    .sout_n     (sout_n)
  );

  // R4: the first stage captures the serial input on an enabled edge
  a_r4_serial_enters_first: assert property (@(posedge clk) disable iff (!load_n)
    (load_n && !hold) |=> (stage[0] == $past(ser_in)));
endmodule

// File: tb/sim_psr_shifter.sv
`timescale 1ns/1ps
module sim_psr_shifter;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         load_n = 1'b1;
  logic         hold   = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         sout, sout_n;

  int checks = 0;
  int fails  = 0;
  bit armed  = 0;
  bit mdl[$];

  psr_shifter #(.DEPTH(W)) u0 (
    .clk(clk), .load_n(load_n), .hold(hold), .ser_in(ser_in),
    .par_in(par_in), .sout(sout), .sout_n(sout_n)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_model();
    mdl.delete();
    for (int i = 0; i < W; i++) mdl.push_back(par_in[i]);
  endtask

  function automatic logic expect_out();
    return load_n ? logic'(mdl[W-1]) : par_in[W-1];
  endfunction

  // reference model stepped on every edge, compared 1 ns later
  always @(posedge clk) begin
    if (!load_n) load_model();
    else if (!hold) begin
      mdl.push_front(ser_in);
      void'(mdl.pop_back());
    end
    #1;
    if (armed) begin
      check("R1 model", sout, expect_out());
      check("R5 model", sout_n, ~expect_out());
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    logic [15:0]  lf;
    logic         s0;
    repeat (3) @(negedge clk);

    // R2: asynchronous load shows the final bit without an edge
    par_in = 8'hA5; load_n = 1'b0; load_model(); armed = 1;
    #1 check("R2", sout, 1'b1);
    check("R5", sout_n, 1'b0);

    // R3: edges, hold and serial activity during load are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ser_in = ~ser_in; hold = k[0];
      #1 check("R3", sout, 1'b1);
    end
    hold = 1'b0;

    // R8: output follows the parallel input while loading
    @(negedge clk); par_in = 8'h3C;
    #1 check("R8", sout, 1'b0);
    check("R5", sout_n, 1'b1);
    @(negedge clk);

    // R7: release shows the loaded final bit before any edge
    load_n = 1'b1;
    #1 check("R7", sout, 1'b0);

    // R1/R4: shift out the word, feed a serial pattern behind it
    pat = 8'b1011_0010;
    ser_in = pat[0];
    for (int k = 1; k <= W; k++) begin
      @(posedge clk); #1;
      if (k < W) check("R1", sout, par_in[W-1-k]);
      else       check("R4", sout, pat[0]);
      if (k < W) ser_in = pat[k];
    end

    // R6: hold freezes the contents across several edges
    hold = 1'b1; s0 = sout;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1 ser_in = ~ser_in;
      check("R6", sout, s0);
    end
    hold = 1'b0;
    for (int k = 1; k < W; k++) begin
      @(posedge clk); #1 check("R4", sout, pat[k]);
      ser_in = 1'b0;
    end

    // mixed stimulus against the model
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ser_in = lf[0];
      hold   = lf[3] & lf[4];
      par_in = lf[15:8];
      if (lf[7:5] == 3'b000) begin
        load_n = 1'b0; load_model();
        #1 check("R2", sout, par_in[W-1]);
      end else begin
        load_n = 1'b1;
      end
    end
    @(negedge clk); load_n = 1'b1;
    repeat (W + 2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule